// File: doc/BRIEF.md
# External Memory Bus Strobe Controller

This block runs the external memory cycles of an 8-bit microcontroller core over a multiplexed bus. The core raises a one-cycle request with a 16-bit address, a direction bit and, for writes, a data byte. The block then steps through a fixed machine cycle. The low address byte and the data share one 8-bit pad group. The high address byte has its own pad group. An active-low address strobe marks the address, an active-low data strobe marks the transfer, and a direction line tells the memory whether the cycle reads or writes. At the end of the cycle the block returns the captured read byte together with a one-clock done pulse.

Pads are expressed as value/enable pairs so that the chip's pad ring can build the actual three-state buffers. A software-controlled float bit withdraws every enable at once: the strobes, the direction line and both address/data pad groups. The bit is registered, so it takes effect one clock after it changes. Cycles started while the block is floated still run to completion internally, but they leave the bus untouched.

A machine cycle takes five clocks after the request is accepted: setup, address strobe low, turnaround, data strobe low, finish. The block then takes one idle clock before it can accept the next request.

Top module: `extbus_strobe_ctrl`

## Requirements
- R1: During and right after reset, `as_n_o` and `ds_n_o` are 1, `rw_o` is 1, `done_o` is 0, `ready_o` is 1 and `ad_oe_o` is 0.
- R2: A request is accepted only in a clock where `ready_o` is 1. A request raised while a cycle is in progress is ignored: it produces no extra strobe and no bus write.
- R3: The address strobe goes low for exactly one clock, the second clock of the cycle. The low address byte is driven on `ad_o` with `ad_oe_o` high in the clock before the strobe and throughout the strobe, so it is stable at the strobe's rising edge.
- R4: The data strobe goes low exactly once per cycle, for one clock. Its falling edge comes one full clock after the address strobe has risen.
- R5: `rw_o` is 1 for a read and 0 for a write throughout the active clocks of the cycle. It is 1 whenever the block is idle.
- R6: For a write, the write byte is on `ad_o` with `ad_oe_o` high from the clock before the data strobe falls until the clock after it rises.
- R7: For a read, `ad_oe_o` is 0 from the turnaround clock to the end of the cycle. `rdata_o` takes the value present on `ad_i` at the clock edge where the data strobe rises.
- R8: `done_o` is high for exactly one clock, the clock in which the data strobe returns high. `ready_o` is 1 in the following clock.
- R9: One clock after `float_en_i` is set, `ad_oe_o`, `ahi_oe_o` and `ctl_oe_o` are all 0 and stay 0 while the bit is set. A write cycle run while floated leaves the memory contents unchanged.
- R10: While the bus is not floated, `ahi_o` carries the high address byte of the current cycle with `ahi_oe_o` high throughout the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Start a memory cycle (sampled only when ready) |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Cycle address |
| req_wdata_i | input | 8 | Write byte |
| float_en_i | input | 1 | Release all bus pads (registered) |
| ready_o | output | 1 | Block is idle and will accept a request |
| done_o | output | 1 | One-clock pulse at cycle end |
| rdata_o | output | 8 | Last captured read byte |
| ad_i | input | 8 | Shared address/data pad input |
| ad_o | output | 8 | Shared address/data pad output value |
| ad_oe_o | output | 1 | Shared address/data pad output enable |
| ahi_o | output | 8 | High address byte pad value |
| ahi_oe_o | output | 1 | High address byte pad enable |
| as_n_o | output | 1 | Address strobe, active low |
| ds_n_o | output | 1 | Data strobe, active low |
| rw_o | output | 1 | Direction line, 1 = read, 0 = write |
| ctl_oe_o | output | 1 | Enable for strobes and direction line |

## Verification
The bench builds the block with its default widths: a 16-bit address and an 8-bit data path, which gives an 8-bit high address port. Addresses are picked so that their high and low bytes differ. This makes a swap of the two pad groups, or a shared port that still shows the address in the data phase, visible in the phase-by-phase checks. A small memory model behind the pads takes the address at the address strobe and commits writes at the data strobe. Floated writes and writes requested while the block is busy can therefore be checked by reading the target location back afterwards.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_ASLO  = 3'd2,
        PH_TURN  = 3'd3,
        PH_DSLO  = 3'd4,
        PH_FIN   = 3'd5
    } phase_e;

    typedef struct packed {
        logic as_low;
        logic ds_low;
        logic addr_drive;
        logic data_window;
        logic capture;
        logic done;
        logic active;
    } phase_ctl_t;

    function automatic phase_ctl_t decode_phase(input phase_e ph);
        phase_ctl_t c;
        c = '0;
        unique case (ph)
            PH_SETUP: begin c.addr_drive = 1'b1; c.active = 1'b1; end
            PH_ASLO:  begin c.addr_drive = 1'b1; c.as_low = 1'b1; c.active = 1'b1; end
            PH_TURN:  begin c.data_window = 1'b1; c.active = 1'b1; end
            PH_DSLO:  begin c.data_window = 1'b1; c.ds_low = 1'b1;
                            c.capture = 1'b1; c.active = 1'b1; end
            PH_FIN:   begin c.data_window = 1'b1; c.done = 1'b1; c.active = 1'b1; end
            default:  c = '0;
        endcase
        return c;
    endfunction

    function automatic phase_e next_phase(input phase_e ph, input logic req);
        phase_e n;
        unique case (ph)
            PH_IDLE:  n = req ? PH_SETUP : PH_IDLE;
            PH_SETUP: n = PH_ASLO;
            PH_ASLO:  n = PH_TURN;
            PH_TURN:  n = PH_DSLO;
            PH_DSLO:  n = PH_FIN;
            default:  n = PH_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/extbus_phase_fsm.sv
module extbus_phase_fsm
    import extbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req,
    output phase_e phase,
    output logic   accept
);
    phase_e phase_q;

    assign accept = (phase_q == PH_IDLE) && req;
    assign phase  = phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= next_phase(phase_q, req);
    end
endmodule

// File: rtl/extbus_xfer_regs.sv
module extbus_xfer_regs #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] ad_in,
    input  logic              float_en,
    output logic              wr_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              float_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_wr;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 rdata_q <= '0;
        else if (capture && !wr_q) rdata_q <= ad_in;
    end

    always_ff @(posedge clk) begin
        if (rst) float_q <= 1'b0;
        else     float_q <= float_en;
    end
endmodule

// File: rtl/extbus_pad_drive.sv
module extbus_pad_drive
    import extbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  phase_e            phase,
    input  logic              wr_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic              float_q,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] ahi_o,
    output logic              ahi_oe,
    output logic              as_n,
    output logic              ds_n,
    output logic              rw,
    output logic              ctl_oe,
    output logic              done,
    output logic              ready,
    output logic              capture
);
    localparam int HI_W = ADDR_W - DATA_W;

    phase_ctl_t ctl;
    logic       send_data;

    assign ctl       = decode_phase(phase);
    assign send_data = ctl.data_window && wr_q;

    for (genvar b = 0; b < DATA_W; b++) begin : g_admux
        assign ad_o[b] = send_data ? wdata_q[b] : addr_q[b];
    end

    assign ahi_o   = addr_q[ADDR_W-1 -: HI_W];
    assign ad_oe   = !float_q && (ctl.addr_drive || send_data);
    assign ahi_oe  = !float_q;
    assign ctl_oe  = !float_q;
    assign as_n    = !ctl.as_low;
    assign ds_n    = !ctl.ds_low;
    assign rw      = !(ctl.active && wr_q);
    assign done    = ctl.done;
    assign ready   = !ctl.active;
    assign capture = ctl.capture;
endmodule

// File: rtl/extbus_strobe_ctrl.sv
module extbus_strobe_ctrl
    import extbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_i,
    input  logic                     req_wr_i,
    input  logic [ADDR_W-1:0]        req_addr_i,
    input  logic [DATA_W-1:0]        req_wdata_i,
    input  logic                     float_en_i,
    output logic                     ready_o,
    output logic                     done_o,
    output logic [DATA_W-1:0]        rdata_o,
    input  logic [DATA_W-1:0]        ad_i,
    output logic [DATA_W-1:0]        ad_o,
    output logic                     ad_oe_o,
    output logic [ADDR_W-DATA_W-1:0] ahi_o,
    output logic                     ahi_oe_o,
    output logic                     as_n_o,
    output logic                     ds_n_o,
    output logic                     rw_o,
    output logic                     ctl_oe_o
);
    phase_e            phase;
    logic              accept;
    logic              capture;
    logic              wr_q;
    logic              float_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    extbus_phase_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .req    (req_i),
        .phase  (phase),
        .accept (accept)
    );

    extbus_xfer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_wr    (req_wr_i),
        .req_addr  (req_addr_i),
        .req_wdata (req_wdata_i),
        .capture   (capture),
        .ad_in     (ad_i),
        .float_en  (float_en_i),
        .wr_q      (wr_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rdata_q   (rdata_o),
        .float_q   (float_q)
    );

    extbus_pad_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pads (
        .phase   (phase),
        .wr_q    (wr_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .float_q (float_q),
        .ad_o    (ad_o),
        .ad_oe   (ad_oe_o),
        .ahi_o   (ahi_o),
        .ahi_oe  (ahi_oe_o),
        .as_n    (as_n_o),
        .ds_n    (ds_n_o),
        .rw      (rw_o),
        .ctl_oe  (ctl_oe_o),
        .done    (done_o),
        .ready   (ready_o),
        .capture (capture)
    );
endmodule

// File: rtl/extbus_strobe_chk.sv
module extbus_strobe_chk (
    input logic clk,
    input logic rst,
    input logic float_en_i,
    input logic ready_o,
    input logic done_o,
    input logic ad_oe_o,
    input logic ahi_oe_o,
    input logic as_n_o,
    input logic ds_n_o,
    input logic rw_o,
    input logic ctl_oe_o
);
    a_r3_as_one_clock: assert property (@(posedge clk) disable iff (rst)
        !as_n_o |=> as_n_o);

    a_r4_ds_one_clock: assert property (@(posedge clk) disable iff (rst)
        !ds_n_o |=> ds_n_o);

    a_r4_ds_after_as_rise: assert property (@(posedge clk) disable iff (rst)
        $fell(ds_n_o) |-> ($past(as_n_o) && !$past(as_n_o, 2)));

    a_r5_idle_reads: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> rw_o);

    a_r6_write_data_driven: assert property (@(posedge clk) disable iff (rst)
        (!ds_n_o && !rw_o && ctl_oe_o) |-> ad_oe_o);

    a_r7_read_released: assert property (@(posedge clk) disable iff (rst)
        (!ds_n_o && rw_o) |-> !ad_oe_o);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && ready_o));

    a_r9_float_all: assert property (@(posedge clk) disable iff (rst)
        float_en_i |=> (!ad_oe_o && !ahi_oe_o && !ctl_oe_o));
endmodule

bind extbus_strobe_ctrl extbus_strobe_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .float_en_i (float_en_i),
    .ready_o    (ready_o),
    .done_o     (done_o),
    .ad_oe_o    (ad_oe_o),
    .ahi_oe_o   (ahi_oe_o),
    .as_n_o     (as_n_o),
    .ds_n_o     (ds_n_o),
    .rw_o       (rw_o),
    .ctl_oe_o   (ctl_oe_o)
);

// File: tb/test_extbus_strobe_ctrl.sv
module test_extbus_strobe_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        float_en = 1'b0;
    logic        ready, done, ad_oe, ahi_oe, as_n, ds_n, rw, ctl_oe;
    logic [7:0]  rdata, ad_in, ad_out, ahi;

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0]  mem     [256];
    logic [7:0]  exp_mem [256];
    logic [15:0] lat_addr = '0;

    always #2 clk = ~clk;

    extbus_strobe_ctrl i_extbus_strobe_ctrl (
        .clk(clk), .rst(rst), .req_i(req), .req_wr_i(req_wr),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .float_en_i(float_en),
        .ready_o(ready), .done_o(done), .rdata_o(rdata), .ad_i(ad_in),
        .ad_o(ad_out), .ad_oe_o(ad_oe), .ahi_o(ahi), .ahi_oe_o(ahi_oe),
        .as_n_o(as_n), .ds_n_o(ds_n), .rw_o(rw), .ctl_oe_o(ctl_oe)
    );

    // memory device model behind the pads
    assign ad_in = mem[lat_addr[7:0]];
    always @(posedge clk) begin
        if (ctl_oe && !as_n && ad_oe && ahi_oe) lat_addr <= {ahi, ad_out};
        if (ctl_oe && !ds_n && !rw && ad_oe)    mem[lat_addr[7:0]] <= ad_out;
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    task automatic xfer(input logic wr, input logic [15:0] a, input logic [7:0] wd, input logic floated);
        @(negedge clk);
        chk(ready, "R2 ready before request", ready, 1);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);  // setup
        req = 1'b0;
        if (floated) chk(!ad_oe && !ahi_oe && !ctl_oe, "R9 floated setup", {ad_oe, ahi_oe, ctl_oe}, 0);
        else begin
            chk(as_n && ds_n, "R3 setup strobes high", {as_n, ds_n}, 2'b11);
            chk(ad_oe && ad_out == a[7:0], "R3 low address in setup", {ad_oe, ad_out}, {1'b1, a[7:0]});
            chk(ahi_oe && ahi == a[15:8], "R10 high address", {ahi_oe, ahi}, {1'b1, a[15:8]});
            chk(rw == !wr, "R5 direction in setup", rw, !wr);
        end
        @(negedge clk);  // address strobe low
        if (floated) chk(!ad_oe && !ctl_oe, "R9 floated strobe", {ad_oe, ctl_oe}, 0);
        else begin
            chk(!as_n && ds_n, "R3 address strobe low", {as_n, ds_n}, 2'b01);
            chk(ad_oe && ad_out == a[7:0], "R3 address held", {ad_oe, ad_out}, {1'b1, a[7:0]});
        end
        @(negedge clk);  // turnaround
        chk(as_n && ds_n, "R4 turnaround strobes high", {as_n, ds_n}, 2'b11);
        if (floated) chk(!ad_oe, "R9 floated turnaround", ad_oe, 0);
        else if (wr) chk(ad_oe && ad_out == wd, "R6 write data before strobe", {ad_oe, ad_out}, {1'b1, wd});
        else chk(!ad_oe, "R7 read port released", ad_oe, 0);
        @(negedge clk);  // data strobe low
        chk(!ds_n && as_n, "R4 data strobe low", {as_n, ds_n}, 2'b10);
        if (!floated) begin
            chk(rw == !wr, "R5 direction in data phase", rw, !wr);
            if (wr) chk(ad_oe && ad_out == wd, "R6 write data during strobe", {ad_oe, ad_out}, {1'b1, wd});
            else    chk(!ad_oe, "R7 read port released", ad_oe, 0);
        end
        @(negedge clk);  // finish
        chk(ds_n && done, "R8 done with strobe rise", {ds_n, done}, 2'b11);
        if (!floated && wr) chk(ad_oe && ad_out == wd, "R6 write data hold", {ad_oe, ad_out}, {1'b1, wd});
        if (!floated && !wr) chk(rdata == exp_mem[a[7:0]], "R7 read data", rdata, exp_mem[a[7:0]]);
        @(negedge clk);  // idle
        chk(!done && ready && rw && as_n && ds_n, "R8 back to idle",
            {done, ready, rw, as_n, ds_n}, 5'b01111);
        if (wr && !floated) exp_mem[a[7:0]] = wd;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(as_n && ds_n && rw && !done && ready && !ad_oe, "R1 reset state",
            {as_n, ds_n, rw, done, ready, ad_oe}, 6'b111010);
        rst = 1'b0;
        @(negedge clk);
        chk(as_n && ds_n && rw && !done && ready && !ad_oe, "R1 after reset",
            {as_n, ds_n, rw, done, ready, ad_oe}, 6'b111010);
    endtask

    task automatic t_basic();
        xfer(1'b0, 16'h5A21, 8'h00, 1'b0);
        xfer(1'b1, 16'hC342, 8'hE7, 1'b0);
        xfer(1'b0, 16'hC342, 8'h00, 1'b0);
        xfer(1'b1, 16'h0F99, 8'h18, 1'b0);
        xfer(1'b1, 16'h0F99, 8'hA5, 1'b0);
        xfer(1'b0, 16'h0F99, 8'h00, 1'b0);
    endtask

    task automatic t_busy_request();
        @(negedge clk);
        req = 1'b1; req_wr = 1'b1; req_addr = 16'h7733; req_wdata = 8'h3C;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);  // address strobe low: raise an ignored request
        req = 1'b1; req_wr = 1'b1; req_addr = 16'h8866; req_wdata = 8'hF0;
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);  // back to idle
        exp_mem[8'h33] = 8'h3C;
        for (int i = 0; i < 3; i++) begin
            chk(as_n && ready, "R2 no cycle from busy request", {as_n, ready}, 2'b11);
            @(negedge clk);
        end
        xfer(1'b0, 16'h8866, 8'h00, 1'b0);   // must still hold preset content
        xfer(1'b0, 16'h7733, 8'h00, 1'b0);
    endtask

    task automatic t_float();
        @(negedge clk);
        float_en = 1'b1;
        @(negedge clk);
        chk(!ad_oe && !ahi_oe && !ctl_oe, "R9 float applied", {ad_oe, ahi_oe, ctl_oe}, 0);
        xfer(1'b1, 16'h2B44, 8'h77, 1'b1);
        float_en = 1'b0;
        @(negedge clk);
        chk(ahi_oe && ctl_oe, "R9 float released", {ahi_oe, ctl_oe}, 2'b11);
        xfer(1'b0, 16'h2B44, 8'h00, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
        t_reset();
        t_basic();
        t_busy_request();
        t_float();
        repeat (2) @(negedge clk);
        summary();
    end

    initial begin
        #400000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end
endmodule